// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits at the front of a simple in-order 32-bit core. It holds the program counter in a register and looks at a six-byte window that instruction memory returns for the current counter value. From that window it picks out the first instruction and presents its fields. These are the class code, the function code, two register selectors and a 32-bit immediate. It also presents the address of the next sequential instruction and a flag for an unknown class code.

Decoding is purely combinational from the counter register and the window. A separate next-address selector outside this block chooses the following counter value. It feeds that value back through a load input. Instructions are one, two, five or six bytes long. Jumps and calls carry their immediate straight after the opcode byte. The other immediate-carrying instructions place a register byte first.

Top module: `ifetch_decode`

## Requirements
- R1: With `rst_n` low at a rising clock edge, `pc` becomes `RESET_PC` (default 0) at that edge.
- R2: Out of reset, `pc` takes `pc_next` at a rising edge when `pc_load` is high, and keeps its value when `pc_load` is low.
- R3: Window byte 0 is `fetch_win[7:0]`, byte k is `fetch_win[8k+7:8k]`. `op_class` equals bits 7:4 of byte 0 and `op_func` equals bits 3:0 of byte 0, for every code.
- R4: `seq_pc` equals `pc` plus the length. The length is 1 for classes 0x0, 0x1 and 0x9. It is 2 for 0x2, 0x6, 0xA and 0xB. It is 5 for 0x7 and 0x8. It is 6 for 0x3, 0x4 and 0x5.
- R5: For classes 0x2 to 0x6, 0xA and 0xB, `reg_a` is bits 7:4 of byte 1 and `reg_b` is bits 3:0 of byte 1. For every other class both read 0x8, meaning no register.
- R6: For classes 0x7 and 0x8, `imm` is bytes 1 to 4 assembled little-endian, with byte 1 in bits 7:0.
- R7: For classes 0x3, 0x4 and 0x5, `imm` is bytes 2 to 5 assembled little-endian, with byte 2 in bits 7:0.
- R8: For classes without an immediate (0x0 to 0x2, 0x6, 0x9 to 0xF), `imm` is zero.
- R9: `bad_op` is high exactly for classes 0xC to 0xF. In that case the length is 1, so `seq_pc` is `pc`+1.
- R10: `seq_pc` wraps modulo 2^32. For example, `pc`=0xFFFFFFFC with a 6-byte instruction gives 0x00000002.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_load | input | 1 | Load `pc_next` into the counter |
| pc_next | input | 32 | Next counter value from the external selector |
| fetch_win | input | 48 | Six instruction bytes read at `pc`, byte 0 lowest |
| pc | output | 32 | Current program counter |
| op_class | output | 4 | Instruction class code |
| op_func | output | 4 | Function code |
| reg_a | output | 4 | First register selector, 0x8 when absent |
| reg_b | output | 4 | Second register selector, 0x8 when absent |
| imm | output | 32 | Immediate or destination constant, zero when absent |
| seq_pc | output | 32 | Address of the next sequential instruction |
| bad_op | output | 1 | Unknown class code |

## Verification
The assertions assume that `fetch_win` and `pc_next` hold known values from the first clock edge. They also treat every window as a legal input, whatever the class code, because the decoder must answer sensibly even for an unknown code. The stimulus drives all inputs from time zero. It changes them only on falling edges, and it sweeps all sixteen class codes over fully random register bytes and immediates. A top-of-range counter value exercises the wrap of the next address.

// File: rtl/ifd_pkg.sv
// Package: shared constants and the per-class shape record for the fetch decoder.
// Assumes a 4-bit class code taken from the upper nibble of the opcode byte.
package ifd_pkg;

    localparam logic [3:0] OP_HALT  = 4'h0;
    localparam logic [3:0] OP_NOP   = 4'h1;
    localparam logic [3:0] OP_RRMOV = 4'h2;
    localparam logic [3:0] OP_IRMOV = 4'h3;
    localparam logic [3:0] OP_RMMOV = 4'h4;
    localparam logic [3:0] OP_MRMOV = 4'h5;
    localparam logic [3:0] OP_ALU   = 4'h6;
    localparam logic [3:0] OP_JUMP  = 4'h7;
    localparam logic [3:0] OP_CALL  = 4'h8;
    localparam logic [3:0] OP_RET   = 4'h9;
    localparam logic [3:0] OP_PUSH  = 4'hA;
    localparam logic [3:0] OP_POP   = 4'hB;

    localparam logic [3:0] NO_REG   = 4'h8;

    // Shape of one instruction: which optional parts follow the opcode byte.
    typedef struct packed {
        logic       has_reg;
        logic       has_const;
        logic       bad;
        logic [3:0] len;
    } shape_t;

endpackage

// File: rtl/ifd_shape.sv
// Module: ifd_shape
// Maps a class code to the instruction layout (register byte, constant, length).
// Assumes a WORD_BYTES-wide constant; lengths are derived from it.
module ifd_shape #(
    parameter int WORD_BYTES = 4
) (
    input  logic [3:0]      op_class,
    output ifd_pkg::shape_t shape
);
    import ifd_pkg::*;

    localparam logic [3:0] LEN_SHORT = 4'd1;
    localparam logic [3:0] LEN_REG   = 4'd2;
    localparam logic [3:0] LEN_JUMP  = 4'(1 + WORD_BYTES);
    localparam logic [3:0] LEN_FULL  = 4'(2 + WORD_BYTES);

    // Classify the opcode into its layout.
    always_comb begin
        shape = '{has_reg: 1'b0, has_const: 1'b0, bad: 1'b0, len: LEN_SHORT};
        case (op_class)
            OP_HALT, OP_NOP, OP_RET: ;
            OP_RRMOV, OP_ALU, OP_PUSH, OP_POP: begin
                shape.has_reg = 1'b1;
                shape.len     = LEN_REG;
            end
            OP_IRMOV, OP_RMMOV, OP_MRMOV: begin
                shape.has_reg   = 1'b1;
                shape.has_const = 1'b1;
                shape.len       = LEN_FULL;
            end
            OP_JUMP, OP_CALL: begin
                shape.has_const = 1'b1;
                shape.len       = LEN_JUMP;
            end
            default: shape.bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/ifd_fields.sv
// Module: ifd_fields
// Extracts register selectors and the little-endian constant from the bytes
// after the opcode. Assumes TAIL_BYTES >= WORD_BYTES + 1.
module ifd_fields #(
    parameter int TAIL_BYTES = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [8*TAIL_BYTES-1:0] tail,
    input  logic                    has_reg,
    input  logic                    has_const,
    output logic [3:0]              reg_a,
    output logic [3:0]              reg_b,
    output logic [8*WORD_BYTES-1:0] imm
);
    import ifd_pkg::*;

    localparam int WORD_W = 8 * WORD_BYTES;

    logic [7:0]        tb [TAIL_BYTES];
    logic [WORD_W-1:0] imm_after_reg;
    logic [WORD_W-1:0] imm_direct;

    genvar g;
    generate
        for (g = 0; g < TAIL_BYTES; g++) begin : g_split
            assign tb[g] = tail[8*g +: 8];
        end
        for (g = 0; g < WORD_BYTES; g++) begin : g_word
            assign imm_direct[8*g +: 8]    = tb[g];
            assign imm_after_reg[8*g +: 8] = tb[g + 1];
        end
    endgenerate

    // Register selectors from the first tail byte, or the no-register code.
    always_comb begin
        reg_a = has_reg ? tb[0][7:4] : NO_REG;
        reg_b = has_reg ? tb[0][3:0] : NO_REG;
    end

    // Constant position depends on whether a register byte precedes it.
    always_comb begin
        if (!has_const)   imm = '0;
        else if (has_reg) imm = imm_after_reg;
        else              imm = imm_direct;
    end

endmodule

// File: rtl/ifd_pc_reg.sv
// Module: ifd_pc_reg
// Program counter register with synchronous active-low reset and load enable.
module ifd_pc_reg #(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] pc_in,
    output logic [ADDR_W-1:0] pc
);

    // Hold, reset or load the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc <= RESET_PC;
        else if (load) pc <= pc_in;
    end

    assert_pc_reset_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> pc == RESET_PC);

    assert_pc_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(load) |-> pc == $past(pc_in));

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(load) |-> $stable(pc));

endmodule

// File: rtl/ifetch_decode.sv
// Module: ifetch_decode (top)
// Holds the PC and decodes the first instruction of the byte window read at it.
// Assumes the window is WIN_BYTES bytes, byte 0 in the lowest bits.
module ifetch_decode #(
    parameter int                ADDR_W     = 32,
    parameter int                WORD_BYTES = 4,
    parameter int                WIN_BYTES  = 6,
    parameter logic [ADDR_W-1:0] RESET_PC   = '0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pc_load,
    input  logic [ADDR_W-1:0]       pc_next,
    input  logic [8*WIN_BYTES-1:0]  fetch_win,
    output logic [ADDR_W-1:0]       pc,
    output logic [3:0]              op_class,
    output logic [3:0]              op_func,
    output logic [3:0]              reg_a,
    output logic [3:0]              reg_b,
    output logic [8*WORD_BYTES-1:0] imm,
    output logic [ADDR_W-1:0]       seq_pc,
    output logic                    bad_op
);
    import ifd_pkg::*;

    localparam int TAIL_BYTES = WIN_BYTES - 1;

    shape_t shape;

    ifd_pc_reg #(.ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_pc (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (pc_load),
        .pc_in (pc_next),
        .pc    (pc)
    );

    // Opcode byte split into class and function.
    always_comb begin
        op_class = fetch_win[7:4];
        op_func  = fetch_win[3:0];
    end

    ifd_shape #(.WORD_BYTES(WORD_BYTES)) u_shape (
        .op_class (op_class),
        .shape    (shape)
    );

    ifd_fields #(.TAIL_BYTES(TAIL_BYTES), .WORD_BYTES(WORD_BYTES)) u_fields (
        .tail      (fetch_win[8*WIN_BYTES-1:8]),
        .has_reg   (shape.has_reg),
        .has_const (shape.has_const),
        .reg_a     (reg_a),
        .reg_b     (reg_b),
        .imm       (imm)
    );

    // Next sequential address, wrapping at the address width.
    always_comb begin
        seq_pc = pc + ADDR_W'(shape.len);
        bad_op = shape.bad;
    end

    assert_bad_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> seq_pc == pc + 1);

    assert_bad_fields_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_op |-> (reg_a == NO_REG && reg_b == NO_REG));

    assert_no_imm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OP_NOP || op_class == OP_RET || bad_op) |-> imm == '0);

    assert_jump_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_class == OP_JUMP || op_class == OP_CALL) |->
            (seq_pc - pc) == ADDR_W'(1 + WORD_BYTES));

endmodule

// File: tb/ifetch_decode_tb.sv
module ifetch_decode_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_load = 1'b0;
    logic [31:0] pc_next = '0;
    logic [47:0] fetch_win = '0;
    logic [31:0] pc, imm, seq_pc;
    logic [3:0]  op_class, op_func, reg_a, reg_b;
    logic        bad_op;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ifetch_decode u_dut (
        .clk(clk), .rst_n(rst_n), .pc_load(pc_load), .pc_next(pc_next),
        .fetch_win(fetch_win), .pc(pc), .op_class(op_class), .op_func(op_func),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .seq_pc(seq_pc), .bad_op(bad_op)
    );

    function automatic int exp_len(input logic [3:0] c);
        case (c)
            4'h2, 4'h6, 4'hA, 4'hB: return 2;
            4'h3, 4'h4, 4'h5:       return 6;
            4'h7, 4'h8:             return 5;
            default:                return 1;
        endcase
    endfunction

    function automatic bit exp_has_reg(input logic [3:0] c);
        return (c >= 4'h2 && c <= 4'h6) || c == 4'hA || c == 4'hB;
    endfunction

    function automatic logic [31:0] exp_imm(input logic [3:0] c, input logic [47:0] w);
        if (c == 4'h7 || c == 4'h8) return w[39:8];
        if (c >= 4'h3 && c <= 4'h5) return w[47:16];
        return 32'h0;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Load a PC and window, then check every decoded output.
    task automatic run_vec(input logic [31:0] p, input logic [47:0] w);
        logic [3:0] c;
        @(negedge clk);
        pc_next = p; pc_load = 1'b1; fetch_win = w;
        @(negedge clk);
        pc_load = 1'b0;
        c = w[7:4];
        check("R2 load", pc, p);
        check("R3 class", {28'h0, op_class}, {28'h0, c});
        check("R3 func", {28'h0, op_func}, {28'h0, w[3:0]});
        check("R4/R10 seq", seq_pc, p + 32'(exp_len(c)));
        check("R5 rega", {28'h0, reg_a}, {28'h0, exp_has_reg(c) ? w[15:12] : 4'h8});
        check("R5 regb", {28'h0, reg_b}, {28'h0, exp_has_reg(c) ? w[11:8] : 4'h8});
        check("R6/R7/R8 imm", imm, exp_imm(c, w));
        check("R9 bad", {31'h0, bad_op}, {31'h0, c >= 4'hC});
        @(negedge clk);
        check("R2 hold", pc, p);
    endtask

    initial begin
        int seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        check("R1 reset", pc, 32'h0);
        rst_n = 1'b1;
        // Directed: every class code at a wrapping address (R10).
        for (int c = 0; c < 16; c++)
            run_vec(32'hFFFF_FFFC, {40'hA1B2C3D4E5, 4'(c), 4'h3});
        // Directed: R6 jump and R7 irmov-style with fixed bytes.
        run_vec(32'h100, 48'h665544332270);
        run_vec(32'h200, 48'h66554433F830);
        // Random mix.
        for (int i = 0; i < 400; i++)
            run_vec($urandom, {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF);
        // Reset mid-run returns the counter to its start value.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", pc, 32'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule